// File: doc/BRIEF.md
# Asynchronous Serial Line Transmitter with Line Inversion

This block serialises one character at a time onto a single transmit line. A character frame is a low start bit, then the data bits least significant first, then a high stop bit. A length control picks eight or nine data bits. In nine-bit mode the extra bit comes from its own input. It can carry a parity value or an address mark, or it can be held high so that it works as a second stop bit. The block can also send two special frames. An idle frame holds the line high for a whole character time. A break frame holds it low for a whole character time and then high for one bit time.

An external baud-tick strobe paces every bit, one strobe per bit time. A polarity control complements every level the block drives: rest, start, data, stop, idle and break. At the first clock edge of a frame the block captures the polarity, the length and the data, and it holds those copies until the frame ends. Busy reports that a frame is in progress. Done pulses for one cycle when a frame finishes.

The controller has five states:
- `S_REST`: the line rests and requests are accepted.
- `S_CHAR`: a character frame is being sent.
- `S_FILL`: an idle frame is being sent.
- `S_BRK`: the low part of a break frame is being sent.
- `S_BRK_MARK`: the trailing high bit of a break frame is being sent.

The transitions are:
- `S_REST` to `S_BRK`, `S_FILL` or `S_CHAR` on an accepted request.
- `S_CHAR` or `S_FILL` to `S_REST` on the tick that ends the last bit, which also raises done.
- `S_BRK` to `S_BRK_MARK` on the tick that ends its last low bit.
- `S_BRK_MARK` to `S_REST` on its tick, which also raises done.
- Every frame state stays where it is on a cycle with no tick.

Top module: `stx_core`

## Requirements
- R1: After reset, busy and done are 0 and txd is 1 while invert_sel is 0.
- R2: With len9_sel=0, a character frame has 10 bit times: 0, then data_in[0] through data_in[7] in that order, then 1.
- R3: With len9_sel=1, a character frame has 11 bit times: 0, then data_in[0] through data_in[7], then bit9_in, then 1. With bit9_in=1 the line stays high for two bit times after the data.
- R4: While busy, txd changes only at the clock edge that samples baud_tick high. Each bit is held for as many cycles as the tick stays low.
- R5: With invert_sel=1, every level on txd is the complement of its R1, R2, R3, R6 and R7 value, including the rest level.
- R6: An idle frame drives 1 for 10 bit times (len9_sel=0) or for 11 bit times (len9_sel=1).
- R7: A break frame drives 0 for 10 or 11 bit times, following len9_sel, and then 1 for one bit time.
- R8: When several requests are high at once, break_req wins over idle_req, and idle_req wins over send_req.
- R9: While tx_enable is 0, no request starts a frame.
- R10: Requests made while busy are ignored. Changes to invert_sel, len9_sel, data_in and bit9_in during a frame do not change that frame.
- R11: Done is high for exactly one cycle, right after the edge that ends the last bit. Busy falls at that same edge.
- R12: An accepted request raises busy and drives the first bit of the frame in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle strobe marking the end of a bit time |
| tx_enable | input | 1 | Allows requests to start frames |
| data_in | input | DATA_W | Character data, sent least significant bit first |
| bit9_in | input | 1 | Extra data bit used in nine-bit mode |
| len9_sel | input | 1 | 0: eight data bits, 1: nine data bits |
| invert_sel | input | 1 | 1: complement every level on txd |
| send_req | input | 1 | Request a character frame |
| idle_req | input | 1 | Request an idle frame |
| break_req | input | 1 | Request a break frame |
| txd | output | 1 | Serial transmit line |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when a frame finishes |

## Verification
The checker watches several rules on every cycle:
- the rest level follows the polarity control;
- the line holds steady between ticks while busy;
- done is a lone pulse that never overlaps busy;
- a disabled block stays at rest;
- the first bit of each frame kind, with break taking priority, appears right after acceptance.

Only the bench scenarios can show the full bit order of each frame. The sweeps cover every byte in both lengths and both polarities, the trailing high bit of a break, the 11-bit idle length, and mid-frame changes to controls and requests that must be ignored.

// File: rtl/stx_pkg.sv
package stx_pkg;

    typedef enum logic [2:0] {
        S_REST,
        S_CHAR,
        S_FILL,
        S_BRK,
        S_BRK_MARK
    } stx_state_e;

    typedef struct packed {
        logic inv;
        logic len9;
    } stx_cfg_t;

endpackage

// File: rtl/stx_bit_counter.sv
module stx_bit_counter #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [IDX_W-1:0] idx
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (advance) begin
            idx <= idx + IDX_W'(1);
        end
    end

endmodule

// File: rtl/stx_frame_latch.sv
module stx_frame_latch
    import stx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  logic              bit9_in,
    input  logic              len9_sel,
    input  logic              invert_sel,
    output logic [DATA_W:0]   word_q,
    output stx_cfg_t          cfg_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            cfg_q  <= '{inv: 1'b0, len9: 1'b0};
        end else if (load) begin
            word_q <= {bit9_in, data_in};
            cfg_q  <= '{inv: invert_sel, len9: len9_sel};
        end
    end

endmodule

// File: rtl/stx_ctrl.sv
module stx_ctrl
    import stx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             tx_enable,
    input  logic             send_req,
    input  logic             idle_req,
    input  logic             break_req,
    input  logic             len9_q,
    input  logic [IDX_W-1:0] idx,
    output stx_state_e       state,
    output logic             load,
    output logic             cnt_clear,
    output logic             cnt_adv,
    output logic             done
);

    stx_state_e       state_nx;
    logic             accept;
    logic             at_last;
    logic             done_set;
    logic [IDX_W-1:0] last_idx;

    assign last_idx = IDX_W'(DATA_W + 1) + IDX_W'(len9_q);
    assign at_last  = (idx == last_idx);
    assign accept   = tx_enable && (send_req || idle_req || break_req);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_REST: begin
                if (accept) begin
                    if (break_req)     state_nx = S_BRK;
                    else if (idle_req) state_nx = S_FILL;
                    else               state_nx = S_CHAR;
                end
            end
            S_CHAR, S_FILL: begin
                if (baud_tick && at_last) state_nx = S_REST;
            end
            S_BRK: begin
                if (baud_tick && at_last) state_nx = S_BRK_MARK;
            end
            S_BRK_MARK: begin
                if (baud_tick) state_nx = S_REST;
            end
            default: state_nx = S_REST;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_REST;
        end else begin
            state <= state_nx;
        end
    end

    // Output decode
    always_comb begin
        load      = 1'b0;
        cnt_clear = 1'b0;
        cnt_adv   = 1'b0;
        done_set  = 1'b0;
        unique case (state)
            S_REST: begin
                load      = accept;
                cnt_clear = accept;
            end
            S_CHAR, S_FILL: begin
                cnt_adv  = baud_tick && !at_last;
                done_set = baud_tick && at_last;
            end
            S_BRK: begin
                cnt_adv   = baud_tick && !at_last;
                cnt_clear = baud_tick && at_last;
            end
            S_BRK_MARK: begin
                done_set = baud_tick;
            end
            default: begin
                cnt_clear = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= done_set;
        end
    end

endmodule

// File: rtl/stx_core.sv
module stx_core
    import stx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_enable,
    input  logic [DATA_W-1:0] data_in,
    input  logic              bit9_in,
    input  logic              len9_sel,
    input  logic              invert_sel,
    input  logic              send_req,
    input  logic              idle_req,
    input  logic              break_req,
    output logic              txd,
    output logic              busy,
    output logic              done
);

    localparam int IDX_W = $clog2(DATA_W + 4);

    stx_state_e       state;
    stx_cfg_t         cfg_q;
    logic [DATA_W:0]  word_q;
    logic [DATA_W:0]  word_sh;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] data_top;
    logic             load;
    logic             cnt_clear;
    logic             cnt_adv;
    logic             level;
    logic             polarity;

    stx_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .tx_enable (tx_enable),
        .send_req  (send_req),
        .idle_req  (idle_req),
        .break_req (break_req),
        .len9_q    (cfg_q.len9),
        .idx       (idx),
        .state     (state),
        .load      (load),
        .cnt_clear (cnt_clear),
        .cnt_adv   (cnt_adv),
        .done      (done)
    );

    stx_bit_counter #(.IDX_W(IDX_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clear),
        .advance (cnt_adv),
        .idx     (idx)
    );

    stx_frame_latch #(.DATA_W(DATA_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .data_in    (data_in),
        .bit9_in    (bit9_in),
        .len9_sel   (len9_sel),
        .invert_sel (invert_sel),
        .word_q     (word_q),
        .cfg_q      (cfg_q)
    );

    // Highest bit index that carries data in a character frame
    assign data_top = IDX_W'(DATA_W) + IDX_W'(cfg_q.len9);
    assign word_sh  = word_q >> (idx - IDX_W'(1));

    // Uninverted line level per state
    always_comb begin
        level = 1'b1;
        unique case (state)
            S_REST:     level = 1'b1;
            S_CHAR: begin
                if (idx == '0)             level = 1'b0;
                else if (idx <= data_top)  level = word_sh[0];
                else                       level = 1'b1;
            end
            S_FILL:     level = 1'b1;
            S_BRK:      level = 1'b0;
            S_BRK_MARK: level = 1'b1;
            default:    level = 1'b1;
        endcase
    end

    assign busy     = (state != S_REST);
    assign polarity = busy ? cfg_q.inv : invert_sel;
    assign txd      = level ^ polarity;

endmodule

// File: rtl/stx_core_chk.sv
module stx_core_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic tx_enable,
    input logic invert_sel,
    input logic send_req,
    input logic idle_req,
    input logic break_req,
    input logic txd,
    input logic busy,
    input logic done
);

    // R5
    rest_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (txd == !invert_sel));

    // R4
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !baud_tick) |=> (busy && $stable(txd)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !tx_enable) |=> !busy);

    // R12
    send_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tx_enable && send_req && !idle_req && !break_req)
        |=> (busy && txd == $past(invert_sel)));

    // R8
    brk_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tx_enable && break_req)
        |=> (busy && txd == $past(invert_sel)));

    // R6
    idle_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tx_enable && idle_req && !break_req)
        |=> (busy && txd == !$past(invert_sel)));

endmodule

bind stx_core stx_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .tx_enable  (tx_enable),
    .invert_sel (invert_sel),
    .send_req   (send_req),
    .idle_req   (idle_req),
    .break_req  (break_req),
    .txd        (txd),
    .busy       (busy),
    .done       (done)
);

// File: tb/stx_core_test.sv
module stx_core_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       tx_enable = 1'b0;
    logic [7:0] data_in = '0;
    logic       bit9_in = 1'b0;
    logic       len9_sel = 1'b0;
    logic       invert_sel = 1'b0;
    logic       send_req = 1'b0;
    logic       idle_req = 1'b0;
    logic       break_req = 1'b0;
    logic       txd;
    logic       busy;
    logic       done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    stx_core #(.DATA_W(8)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .tx_enable  (tx_enable),
        .data_in    (data_in),
        .bit9_in    (bit9_in),
        .len9_sel   (len9_sel),
        .invert_sel (invert_sel),
        .send_req   (send_req),
        .idle_req   (idle_req),
        .break_req  (break_req),
        .txd        (txd),
        .busy       (busy),
        .done       (done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // kind: 0 character, 1 idle, 2 break
    function automatic bit exp_level(input int kind, input int i, input logic [7:0] d,
                                     input bit b9, input bit l9, input bit inv);
        int  nb;
        bit  lv;
        nb = l9 ? 11 : 10;
        if (kind == 0) begin
            if (i == 0)      lv = 1'b0;
            else if (i <= 8) lv = d[i-1];
            else if (i == 9) lv = l9 ? b9 : 1'b1;
            else             lv = 1'b1;
        end else if (kind == 1) begin
            lv = 1'b1;
        end else begin
            lv = (i < nb) ? 1'b0 : 1'b1;
        end
        return lv ^ inv;
    endfunction

    task automatic run_frame(input int kind, input logic [2:0] reqs, input logic [7:0] d,
                             input bit b9, input bit l9, input bit inv, input int gap,
                             input bit perturb, input string req);
        int total;
        total = (l9 ? 11 : 10) + ((kind == 2) ? 1 : 0);
        @(negedge clk);
        data_in    = d;
        bit9_in    = b9;
        len9_sel   = l9;
        invert_sel = inv;
        tx_enable  = 1'b1;
        {break_req, idle_req, send_req} = reqs;
        @(negedge clk);
        {break_req, idle_req, send_req} = 3'b000;
        // R12: busy in the cycle after acceptance
        chk(busy == 1'b1, "R12", busy, 1);
        for (int i = 0; i < total; i++) begin
            chk(txd == exp_level(kind, i, d, b9, l9, inv), req, txd,
                exp_level(kind, i, d, b9, l9, inv));
            if (perturb && i == 2) begin
                // R10: mid-frame changes and requests
                invert_sel = ~inv;
                len9_sel   = ~l9;
                data_in    = ~d;
                bit9_in    = ~b9;
                send_req   = 1'b1;
                break_req  = 1'b1;
            end
            if (perturb && i == 3) begin
                send_req  = 1'b0;
                break_req = 1'b0;
            end
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                // R4: held without a tick
                chk(txd == exp_level(kind, i, d, b9, l9, inv), "R4", txd,
                    exp_level(kind, i, d, b9, l9, inv));
            end
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
        // R11
        chk(done == 1'b1, "R11", done, 1);
        chk(busy == 1'b0, "R11", busy, 0);
        chk(txd == !invert_sel, "R5", txd, !invert_sel);
        invert_sel = inv;
        @(negedge clk);
        chk(done == 1'b0, "R11", done, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1", busy, 0);
        chk(done == 1'b0, "R1", done, 0);
        chk(txd == 1'b1, "R1", txd, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R1", txd, 1);

        // R2, R3, R5: full byte sweep in both lengths and polarities
        for (int l = 0; l < 2; l++) begin
            for (int v = 0; v < 2; v++) begin
                for (int d = 0; d < 256; d++) begin
                    logic [7:0] db;
                    db = 8'(d);
                    run_frame(0, 3'b001, db, ^db, bit'(l), bit'(v), 0, 1'b0,
                              (v != 0) ? "R5" : ((l != 0) ? "R3" : "R2"));
                end
            end
        end

        // R3: ninth bit high acts as a second stop bit
        run_frame(0, 3'b001, 8'h5A, 1'b1, 1'b1, 1'b0, 1, 1'b0, "R3");

        // R6 and R7 in both lengths and polarities, with held bits (R4)
        for (int l = 0; l < 2; l++) begin
            for (int v = 0; v < 2; v++) begin
                run_frame(1, 3'b010, 8'h00, 1'b0, bit'(l), bit'(v), 2, 1'b0, "R6");
                run_frame(2, 3'b100, 8'h00, 1'b0, bit'(l), bit'(v), 3, 1'b0, "R7");
            end
        end

        // R8: priority among simultaneous requests
        run_frame(2, 3'b111, 8'hC3, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R8");
        run_frame(1, 3'b011, 8'hC3, 1'b0, 1'b1, 1'b0, 0, 1'b0, "R8");
        run_frame(2, 3'b110, 8'hC3, 1'b0, 1'b0, 1'b1, 0, 1'b0, "R8");

        // R10: controls and requests changed during a frame
        run_frame(0, 3'b001, 8'hB4, 1'b1, 1'b1, 1'b0, 1, 1'b1, "R10");
        run_frame(0, 3'b001, 8'h2D, 1'b0, 1'b0, 1'b1, 0, 1'b1, "R10");
        @(negedge clk);
        chk(busy == 1'b0, "R10", busy, 0);

        // R9: requests ignored while disabled
        @(negedge clk);
        tx_enable  = 1'b0;
        invert_sel = 1'b1;
        send_req   = 1'b1;
        idle_req   = 1'b1;
        break_req  = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(busy == 1'b0, "R9", busy, 0);
            chk(txd == 1'b0, "R9", txd, 0);
        end
        {break_req, idle_req, send_req} = 3'b000;
        invert_sel = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R5", txd, 1);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule